// File: doc/BRIEF.md
# Cache Request Admission and Blocking Controller

This block decides whether new work may enter the two allocation queues of a cache: a miss queue, which holds outstanding fills and uncached reads, and a write queue, which holds outgoing writes. It keeps an occupancy count per queue. It also keeps a three-bit mask of reasons why the cache cannot take requests. While any reason is present, it holds a stall on the requester-facing interface. When the last reason goes away, it sends one retry pulse to any requester that was turned away during the stall.

Allocations arrive over a valid/ready handshake. Each one carries a request kind, an address, a byte size and a flag that asks for a memory-side send. The block works out which queue the request goes to and the address and length that queue records, and stamps the request with a sequence number. When the flag is set, it raises a memory-side send request that names the queue. The block also keeps, for each reason, a count of blocking episodes and a count of the cycles spent blocked.

Top module: `cache_admit_ctrl`

## Requirements
- R1: The mask `block_mask` has fixed bit meanings: bit 0 = miss queue full, bit 1 = write queue full, bit 2 = an entry has no free target slot. `cpu_stall` is high exactly when the mask is nonzero. Both reset to zero.
- R2: A set or clear event changes only its own bit. Clearing a bit that is not set changes nothing.
- R3: When the mask goes from zero to nonzero, the episode counter of the lowest-indexed cause set in that cycle increases by one. A set while already blocked leaves every episode counter unchanged.
- R4: When a clear leaves the mask at zero, the cycles since the episode began (the edge count between the entry edge and the exit edge) are added to the blocked-cycle counter of the lowest-indexed cause cleared in that cycle.
- R5: `cpu_retry` pulses high for exactly one cycle, in the cycle the stall drops. It does so only if `cpu_req_valid` was high in at least one cycle while `cpu_stall` was high during that episode.
- R6: Kind encoding: 0 = cacheable miss, 1 = uncached read (both go to the miss queue), 2 = write (goes to the write queue), 3 = reserved. `alloc_ready` is high only for kinds 0 to 2 whose target queue is below its depth. An accepted allocation that fills its queue sets that queue's cause bit one cycle after it is accepted.
- R7: `svc_valid` retires one entry from the queue selected by `svc_queue` (0 = miss, 1 = write) when that queue is not empty. It clears the queue's cause bit only if the queue was full before the retirement and is below full after it.
- R8: A cacheable miss records `alloc_addr & ~(BLK_BYTES-1)` and a size of `BLK_BYTES`.
- R9: Writes and uncached reads record `alloc_addr` and `alloc_size` unchanged.
- R10: Each accepted allocation gets a sequence number one higher than the one before, starting at 0 after reset. The number wraps at `ORD_W` bits.
- R11: `send_req` is high in the result cycle of an accepted allocation exactly when `alloc_send` was set. `send_cause` then equals the queue index.
- R12: If `tgt_set` and `tgt_clr` are high in the same cycle, the set wins. Any combination of simultaneous events yields at most one retry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_kind | input | 2 | Request kind (see R6) |
| alloc_addr | input | ADDR_W | Request byte address |
| alloc_size | input | SIZE_W | Request byte length |
| alloc_send | input | 1 | Ask for a memory-side send on acceptance |
| alloc_ready | output | 1 | Target queue can accept the request |
| svc_valid | input | 1 | An entry is put in service and leaves its queue |
| svc_queue | input | 1 | Queue of the serviced entry |
| tgt_set | input | 1 | Target slots of an entry exhausted |
| tgt_clr | input | 1 | Target slot shortage resolved |
| cpu_req_valid | input | 1 | Requester is presenting a request |
| cpu_stall | output | 1 | Requester interface stalled |
| cpu_retry | output | 1 | One-cycle retry pulse to the requester |
| block_mask | output | 3 | Current cause mask |
| res_valid | output | 1 | Allocation recorded last cycle |
| res_queue | output | 1 | Queue of the recorded allocation |
| res_addr | output | ADDR_W | Recorded address |
| res_size | output | SIZE_W | Recorded length |
| res_order | output | ORD_W | Sequence number |
| send_req | output | 1 | Memory-side send request |
| send_cause | output | 2 | Cause tag of the send request |
| episode_cnt | output | 3*CNT_W | Per-cause episode counters, cause 0 in the low slice |
| blocked_cyc | output | 3*CNT_W | Per-cause blocked-cycle counters, cause 0 in the low slice |

## Verification
The assertions assume the environment never drives `alloc_valid` with a result that bypasses `alloc_ready`. They also assume the count of blocked cycles stays far below the counter range. Retirements of an empty queue are legal and ignored. The target-slot cause follows whatever `tgt_set` and `tgt_clr` do, so the stimulus keeps the episodes short and lets both inputs collide on purpose. Random traffic draws all four kinds, including the reserved one, with retirements frequent enough that both queues fill and drain many times within the run.

// File: rtl/cadm_pkg.sv
package cadm_pkg;
  localparam int NCAUSE = 3;
  localparam int CAUSE_MISSQ = 0;
  localparam int CAUSE_WBUF  = 1;
  localparam int CAUSE_TGT   = 2;

  localparam logic [1:0] KIND_MISS   = 2'd0;
  localparam logic [1:0] KIND_UNC_RD = 2'd1;
  localparam logic [1:0] KIND_WRITE  = 2'd2;
  localparam logic [1:0] KIND_RSVD   = 2'd3;

  // queue index for a request kind: write queue for writes, miss queue otherwise
  function automatic logic queue_of(input logic [1:0] kind);
    return kind == KIND_WRITE;
  endfunction

  // lowest set bit of a cause vector (vector assumed nonzero when used)
  function automatic logic [1:0] lowest_cause(input logic [NCAUSE-1:0] v);
    if (v[0]) return 2'd0;
    if (v[1]) return 2'd1;
    return 2'd2;
  endfunction
endpackage

// File: rtl/cadm_qtrack.sv
module cadm_qtrack #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alloc_fire,
  input  logic svc_req,
  output logic full,
  output logic set_ev,
  output logic clr_ev
);
  localparam int OW = $clog2(DEPTH + 1);

  logic [OW-1:0] occ_q, occ_n;
  logic          svc_ok;

  assign svc_ok = svc_req && (occ_q != '0);
  assign occ_n  = occ_q + OW'(alloc_fire) - OW'(svc_ok);
  assign full   = (occ_q == OW'(DEPTH));
  assign set_ev = alloc_fire && (occ_n == OW'(DEPTH));
  assign clr_ev = svc_ok && full && (occ_n != OW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_n;
  end

  // R6
  occ_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH));
  // R6
  no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !full);
  // R6
  set_means_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> full);
  // R7
  clear_only_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !full);
endmodule

// File: rtl/cadm_blockmask.sv
module cadm_blockmask
  import cadm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCAUSE-1:0]       set_vec,
  input  logic [NCAUSE-1:0]       clr_vec,
  input  logic                    req_valid,
  output logic [NCAUSE-1:0]       mask,
  output logic                    stall,
  output logic                    retry,
  output logic [NCAUSE*CNT_W-1:0] episode_flat,
  output logic [NCAUSE*CNT_W-1:0] cycles_flat
);
  logic [NCAUSE-1:0] mask_q, mask_n;
  logic              stall_q, retry_q, pend_q;
  logic [CNT_W-1:0]  cycle_q, start_q;
  logic [CNT_W-1:0]  epi_q [NCAUSE];
  logic [CNT_W-1:0]  cyc_q [NCAUSE];

  // named events for the checks below
  logic       entry_ev, exit_ev, refused;
  logic [1:0] entry_c, exit_c;

  assign mask_n   = (mask_q & ~clr_vec) | set_vec;  // set wins on a collision
  assign entry_ev = (mask_q == '0) && (mask_n != '0);
  assign exit_ev  = (mask_q != '0) && (mask_n == '0);
  assign entry_c  = lowest_cause(set_vec);
  assign exit_c   = lowest_cause(clr_vec & mask_q);
  assign refused  = req_valid && stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      stall_q <= 1'b0;
      retry_q <= 1'b0;
      pend_q  <= 1'b0;
      cycle_q <= '0;
      start_q <= '0;
      for (int c = 0; c < NCAUSE; c++) begin
        epi_q[c] <= '0;
        cyc_q[c] <= '0;
      end
    end else begin
      cycle_q <= cycle_q + 1'b1;
      mask_q  <= mask_n;
      stall_q <= (mask_n != '0);
      retry_q <= exit_ev && (pend_q || refused);
      pend_q  <= exit_ev ? 1'b0 : (pend_q || refused);
      if (entry_ev) start_q <= cycle_q;
      for (int c = 0; c < NCAUSE; c++) begin
        if (entry_ev && entry_c == 2'(c)) epi_q[c] <= epi_q[c] + 1'b1;
        if (exit_ev && exit_c == 2'(c))   cyc_q[c] <= cyc_q[c] + (cycle_q - start_q);
      end
    end
  end

  assign mask  = mask_q;
  assign stall = stall_q;
  assign retry = retry_q;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_flat
    assign episode_flat[g*CNT_W +: CNT_W] = epi_q[g];
    assign cycles_flat[g*CNT_W +: CNT_W]  = cyc_q[g];
  end

  logic [CNT_W+1:0] epi_sum, cyc_sum;
  assign epi_sum = (CNT_W+2)'(epi_q[0]) + (CNT_W+2)'(epi_q[1]) + (CNT_W+2)'(epi_q[2]);
  assign cyc_sum = (CNT_W+2)'(cyc_q[0]) + (CNT_W+2)'(cyc_q[1]) + (CNT_W+2)'(cyc_q[2]);

  // R1
  stall_tracks_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q == (mask_q != '0));
  // R5
  retry_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |-> $fell(stall_q));
  // R12
  retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |=> !retry_q);
  // R3
  episode_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epi_sum != $past(epi_sum)) |-> $rose(stall_q));
  // R4
  cycles_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_sum != $past(cyc_sum)) |-> $fell(stall_q));
endmodule

// File: rtl/cadm_allocfmt.sv
module cadm_allocfmt
  import cadm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 8,
  parameter int BLK_BYTES = 64,
  parameter int ORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              send,
  output logic              res_valid,
  output logic              res_queue,
  output logic [ADDR_W-1:0] res_addr,
  output logic [SIZE_W-1:0] res_size,
  output logic [ORD_W-1:0]  res_order,
  output logic              send_req,
  output logic [1:0]        send_cause
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  function automatic logic [ADDR_W-1:0] block_base(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(BLK_BYTES - 1);
  endfunction

  function automatic logic [ADDR_W-1:0] record_addr(input logic [1:0] k,
                                                    input logic [ADDR_W-1:0] a);
    return (k == KIND_MISS) ? block_base(a) : a;
  endfunction

  function automatic logic [SIZE_W-1:0] record_size(input logic [1:0] k,
                                                    input logic [SIZE_W-1:0] s);
    return (k == KIND_MISS) ? SIZE_W'(BLK_BYTES) : s;
  endfunction

  logic [ORD_W-1:0] next_order_q;
  logic [1:0]       kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_queue    <= 1'b0;
      res_addr     <= '0;
      res_size     <= '0;
      res_order    <= '0;
      send_req     <= 1'b0;
      send_cause   <= 2'd0;
      next_order_q <= '0;
      kind_q       <= KIND_MISS;
    end else begin
      res_valid <= fire;
      send_req  <= fire && send;
      if (fire) begin
        res_queue    <= queue_of(kind);
        res_addr     <= record_addr(kind, addr);
        res_size     <= record_size(kind, size);
        res_order    <= next_order_q;
        send_cause   <= {1'b0, queue_of(kind)};
        next_order_q <= next_order_q + 1'b1;
        kind_q       <= kind;
      end
    end
  end

  // R8
  miss_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && kind_q == KIND_MISS) |-> (res_addr[OFF_W-1:0] == '0 && res_size == SIZE_W'(BLK_BYTES)));
  // R11
  send_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> (res_valid && send_cause == {1'b0, res_queue}));
  // R10
  order_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid)) |-> (res_order == $past(res_order) + 1'b1));
endmodule

// File: rtl/cache_admit_ctrl.sv
module cache_admit_ctrl
  import cadm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 8,
  parameter int BLK_BYTES   = 64,
  parameter int MISSQ_DEPTH = 4,
  parameter int WBUF_DEPTH  = 4,
  parameter int ORD_W       = 16,
  parameter int CNT_W       = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic [1:0]              alloc_kind,
  input  logic [ADDR_W-1:0]       alloc_addr,
  input  logic [SIZE_W-1:0]       alloc_size,
  input  logic                    alloc_send,
  output logic                    alloc_ready,
  input  logic                    svc_valid,
  input  logic                    svc_queue,
  input  logic                    tgt_set,
  input  logic                    tgt_clr,
  input  logic                    cpu_req_valid,
  output logic                    cpu_stall,
  output logic                    cpu_retry,
  output logic [NCAUSE-1:0]       block_mask,
  output logic                    res_valid,
  output logic                    res_queue,
  output logic [ADDR_W-1:0]       res_addr,
  output logic [SIZE_W-1:0]       res_size,
  output logic [ORD_W-1:0]        res_order,
  output logic                    send_req,
  output logic [1:0]              send_cause,
  output logic [NCAUSE*CNT_W-1:0] episode_cnt,
  output logic [NCAUSE*CNT_W-1:0] blocked_cyc
);
  localparam int NQ = 2;

  logic [NQ-1:0]     q_full, q_set, q_clr;
  logic              tgt_q, alloc_fire;
  logic [NCAUSE-1:0] set_vec, clr_vec;

  assign tgt_q       = queue_of(alloc_kind);
  assign alloc_ready = (alloc_kind != KIND_RSVD) && !q_full[tgt_q];
  assign alloc_fire  = alloc_valid && alloc_ready;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    localparam int DEP = (g == 0) ? MISSQ_DEPTH : WBUF_DEPTH;
    cadm_qtrack #(.DEPTH(DEP)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire && (tgt_q == 1'(g))),
      .svc_req    (svc_valid && (svc_queue == 1'(g))),
      .full       (q_full[g]),
      .set_ev     (q_set[g]),
      .clr_ev     (q_clr[g])
    );
  end

  assign set_vec = {tgt_set, q_set[CAUSE_WBUF], q_set[CAUSE_MISSQ]};
  assign clr_vec = {tgt_clr, q_clr[CAUSE_WBUF], q_clr[CAUSE_MISSQ]};

  cadm_blockmask #(.CNT_W(CNT_W)) u_mask (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_vec      (set_vec),
    .clr_vec      (clr_vec),
    .req_valid    (cpu_req_valid),
    .mask         (block_mask),
    .stall        (cpu_stall),
    .retry        (cpu_retry),
    .episode_flat (episode_cnt),
    .cycles_flat  (blocked_cyc)
  );

  cadm_allocfmt #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BLK_BYTES(BLK_BYTES), .ORD_W(ORD_W)
  ) u_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (alloc_fire),
    .kind       (alloc_kind),
    .addr       (alloc_addr),
    .size       (alloc_size),
    .send       (alloc_send),
    .res_valid  (res_valid),
    .res_queue  (res_queue),
    .res_addr   (res_addr),
    .res_size   (res_size),
    .res_order  (res_order),
    .send_req   (send_req),
    .send_cause (send_cause)
  );

  // R6
  reserved_never_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_kind == KIND_RSVD) |-> !alloc_ready);
  // R2
  mask_bits_move_by_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(block_mask));
endmodule

// File: tb/test_cache_admit_ctrl.sv
module test_cache_admit_ctrl;
  localparam int ADDR_W = 32, SIZE_W = 8, BLK = 64, MQD = 4, WBD = 4, ORD_W = 16, CNT_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 0, alloc_send = 0, svc_valid = 0, svc_queue = 0;
  logic [1:0]        alloc_kind = 0;
  logic [ADDR_W-1:0] alloc_addr = 0;
  logic [SIZE_W-1:0] alloc_size = 0;
  logic              tgt_set = 0, tgt_clr = 0, cpu_req_valid = 0;
  logic              alloc_ready, cpu_stall, cpu_retry, res_valid, res_queue, send_req;
  logic [2:0]        block_mask;
  logic [ADDR_W-1:0] res_addr;
  logic [SIZE_W-1:0] res_size;
  logic [ORD_W-1:0]  res_order;
  logic [1:0]        send_cause;
  logic [3*CNT_W-1:0] episode_cnt, blocked_cyc;

  always #2.5 clk = ~clk;

  cache_admit_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BLK_BYTES(BLK), .MISSQ_DEPTH(MQD),
                     .WBUF_DEPTH(WBD), .ORD_W(ORD_W), .CNT_W(CNT_W)) i_cache_admit_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_addr(alloc_addr), .alloc_size(alloc_size), .alloc_send(alloc_send),
    .alloc_ready(alloc_ready), .svc_valid(svc_valid), .svc_queue(svc_queue),
    .tgt_set(tgt_set), .tgt_clr(tgt_clr), .cpu_req_valid(cpu_req_valid),
    .cpu_stall(cpu_stall), .cpu_retry(cpu_retry), .block_mask(block_mask),
    .res_valid(res_valid), .res_queue(res_queue), .res_addr(res_addr),
    .res_size(res_size), .res_order(res_order), .send_req(send_req),
    .send_cause(send_cause), .episode_cnt(episode_cnt), .blocked_cyc(blocked_cyc));

  // ---- behavioural reference ----
  int          m_occ [2];
  int          m_epi [3];
  longint      m_cyc [3];
  longint      m_cycle, m_start;
  int          m_mask, m_order, m_res_order, m_res_q, m_res_kind;
  bit          m_stall, m_retry, m_pend, m_res_valid, m_send;
  logic [ADDR_W-1:0] m_res_addr;
  int          m_res_size;

  function automatic int depth_of(int q);
    return (q == 0) ? MQD : WBD;
  endfunction

  function automatic bit exp_ready();
    int q = (alloc_kind == 2) ? 1 : 0;
    return (alloc_kind != 3) && (m_occ[q] < depth_of(q));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_occ = '{0, 0}; m_epi = '{0, 0, 0}; m_cyc = '{0, 0, 0};
      m_cycle = 0; m_start = 0; m_mask = 0; m_order = 0; m_res_order = 0;
      m_stall = 0; m_retry = 0; m_pend = 0; m_res_valid = 0; m_send = 0;
    end else begin
      int  q, nocc[2], setv, clrv, mn;
      bit  fire, svc_ok, refused, entry, leave;
      q = (alloc_kind == 2) ? 1 : 0;
      fire = alloc_valid && exp_ready();
      svc_ok = svc_valid && m_occ[svc_queue] > 0;
      setv = tgt_set ? 4 : 0;
      clrv = tgt_clr ? 4 : 0;
      for (int g = 0; g < 2; g++) begin
        nocc[g] = m_occ[g] + ((fire && q == g) ? 1 : 0) - ((svc_ok && svc_queue == g) ? 1 : 0);
        if (fire && q == g && nocc[g] == depth_of(g)) setv |= (1 << g);
        if (svc_ok && svc_queue == g && m_occ[g] == depth_of(g) && nocc[g] < depth_of(g)) clrv |= (1 << g);
      end
      mn = (m_mask & ~clrv) | setv;
      entry = (m_mask == 0) && (mn != 0);
      leave = (m_mask != 0) && (mn == 0);
      if (entry) begin
        for (int c = 0; c < 3; c++) if (setv[c]) begin m_epi[c]++; break; end
        m_start = m_cycle;
      end
      if (leave) begin
        for (int c = 0; c < 3; c++) if (clrv[c] && m_mask[c]) begin m_cyc[c] += m_cycle - m_start; break; end
      end
      refused = cpu_req_valid && m_stall;
      m_retry = leave && (m_pend || refused);
      m_pend  = leave ? 0 : (m_pend || refused);
      m_mask  = mn;
      m_stall = (mn != 0);
      m_res_valid = fire;
      m_send = fire && alloc_send;
      if (fire) begin
        m_res_q = q;
        m_res_kind = alloc_kind;
        m_res_addr = (alloc_kind == 0) ? (alloc_addr & ~ADDR_W'(BLK - 1)) : alloc_addr;
        m_res_size = (alloc_kind == 0) ? BLK : int'(alloc_size);
        m_res_order = m_order;
        m_order = (m_order + 1) % (1 << ORD_W);
      end
      m_occ = nocc;
      m_cycle++;
    end
  end

  // ---- checking ----
  int    n_checks = 0, n_errors = 0;
  bit    done = 0;
  string mask_tag = "R1";

  task automatic check(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R6", "alloc_ready", alloc_ready, exp_ready());
    check(mask_tag, "block_mask", block_mask, m_mask);
    check("R1", "cpu_stall", cpu_stall, m_stall);
    check("R5", "cpu_retry", cpu_retry, m_retry);
    check("R6", "res_valid", res_valid, m_res_valid);
    check("R11", "send_req", send_req, m_send);
    if (m_res_valid) begin
      check("R6", "res_queue", res_queue, m_res_q);
      check(m_res_kind == 0 ? "R8" : "R9", "res_addr", res_addr, m_res_addr);
      check(m_res_kind == 0 ? "R8" : "R9", "res_size", res_size, m_res_size);
      check("R10", "res_order", res_order, m_res_order);
      if (m_send) check("R11", "send_cause", send_cause, m_res_q);
    end
    for (int c = 0; c < 3; c++) begin
      check("R3", "episode_cnt", episode_cnt[c*CNT_W +: CNT_W], m_epi[c]);
      check("R4", "blocked_cyc", blocked_cyc[c*CNT_W +: CNT_W], m_cyc[c]);
    end
  endtask

  task automatic tick();
    #1 compare_all();
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_send = 0; svc_valid = 0; tgt_set = 0; tgt_clr = 0; cpu_req_valid = 0;
  endtask

  task automatic alloc(input logic [1:0] k, input logic [31:0] a, input int s, input bit snd);
    idle();
    alloc_valid = 1; alloc_kind = k; alloc_addr = a; alloc_size = SIZE_W'(s); alloc_send = snd;
    tick();
  endtask

  task automatic service(input bit q);
    idle(); svc_valid = 1; svc_queue = q; tick();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // reset state (R1)
    check("R1", "reset mask", block_mask, 0);
    check("R1", "reset stall", cpu_stall, 0);
    check("R10", "reset order", res_order, 0);
    idle(); tick();

    // fill the miss queue with cacheable misses (R6, R8, R11, R3)
    for (int i = 0; i < MQD; i++) alloc(2'd0, 32'h1234_5677 + i * 32'h40, 3, i[0]);
    check("R6", "miss queue full blocks", block_mask, 1);
    alloc(2'd1, 32'h0000_0100, 4, 1);         // refused, queue full (R6)
    idle(); cpu_req_valid = 1; tick();        // requester turned away (R5)
    mask_tag = "R2";
    idle(); tgt_set = 1; tick();              // extra cause while blocked: no new episode (R3)
    idle(); tgt_clr = 1; tgt_set = 0; tick(); // clears only bit 2 (R2)
    idle(); tgt_set = 1; tick();
    mask_tag = "R7";
    service(1'b0);                            // full -> not full clears bit 0 only (R7)
    service(1'b0);                            // not full before: no clear (R7)
    idle(); tick();
    check("R5", "no retry while still blocked", cpu_retry, 0);
    idle(); tgt_clr = 1; tick();              // last cause -> retry pulse, cycles to cause 2 (R4, R5)
    idle(); tick();

    // writes and uncached reads keep exact address and size (R9)
    mask_tag = "R1";
    alloc(2'd1, 32'h0000_0123, 5, 1);
    for (int i = 0; i < WBD; i++) alloc(2'd2, 32'h8000_0003 + i * 7, 1 + i, 1);
    alloc(2'd2, 32'h8000_1000, 9, 1);         // write queue full (R6)
    idle(); tick(); tick();
    service(1'b1);                            // releases with no refused request: no retry (R5)
    idle(); tick();
    alloc(2'd3, 32'h4, 2, 1);                 // reserved kind never accepted (R6)

    // collision: set and clear of bit 2 together, set wins (R12)
    mask_tag = "R12";
    idle(); tgt_set = 1; tgt_clr = 1; tick();
    idle(); cpu_req_valid = 1; tick();
    idle(); tgt_clr = 1; cpu_req_valid = 1; tick();
    idle(); tgt_clr = 1; tick();              // clearing an unset bit: no effect (R2)
    idle(); tick();

    // random traffic
    mask_tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      idle();
      alloc_valid   = ($urandom % 3) != 0;
      alloc_kind    = 2'($urandom % 4);
      alloc_addr    = $urandom;
      alloc_size    = SIZE_W'($urandom % 65);
      alloc_send    = $urandom % 2;
      svc_valid     = ($urandom % 3) == 0;
      svc_queue     = $urandom % 2;
      tgt_set       = ($urandom % 40) == 0;
      tgt_clr       = ($urandom % 10) == 0;
      cpu_req_valid = ($urandom % 2);
      tick();
    end
    idle(); tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule